// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block counts clock cycles from its last refresh. When software fails to refresh it before a programmable time-out, it emits a one-cycle reset request. Software refreshes it by writing a key byte to a write-only kick register. In the optional window mode a refresh is only accepted after a closed interval has run out. A refresh inside that interval counts as a fault, just like a missed time-out. An early-warning flag rises a programmable number of cycles after each restart, and it can drive an interrupt line.

Software reaches the block through a byte-wide register port. A write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The port carries no stream traffic, so it has no valid/ready handshake and never back-pressures. All three interval fields use one 4-bit code. Code n selects 2^(BASE_LOG2+n) cycles, and codes above MAX_CODE are clamped. The defaults (BASE_LOG2=3, MAX_CODE=11) give 8 to 16384 cycles. Register map, as 4-bit addresses:

- 0x0 control: bit 1 run, bit 2 window mode, bit 7 lock.
- 0x1 config: bits 3:0 time-out code, bits 7:4 closed-window code.
- 0x2 warning: bits 3:0 warning code.
- 0x4 and 0x5 interrupt enable clear and set, both on bit 0.
- 0x6 warning flag, bit 0.
- 0x7 status.
- 0x8 kick, write-only, key 0xA5.

Top module: `win_watchdog`

## Requirements
- R1: After reset, reads return 0x00 at 0x0, 0xBB at 0x1, 0x0B at 0x2, 0x00 at 0x4, 0x5, 0x6, 0x7 and 0x8, and both outputs are low.
- R2: With run set (control bit 1) and window mode clear, `wdt_reset` pulses exactly T cycles after the write that set run, or after the last restart. T = 2^(BASE_LOG2+min(code,MAX_CODE)) for the time-out code in config bits 3:0.
- R3: Writing 0xA5 to 0x8 while running restarts the count, so the next time-out comes T cycles after that write.
- R4: Writing any byte other than 0xA5 to 0x8 while running raises `wdt_reset` in the cycle after the write. While run is clear, writes to 0x8 have no effect.
- R5: In window mode (control bit 2), let W be the interval selected by the window code in config bits 7:4. A key write while fewer than W cycles have passed since restart raises `wdt_reset`. A key write after that restarts the count. With no key write, `wdt_reset` pulses W+T cycles after restart.
- R6: The warning flag (0x6 bit 0) rises E cycles after restart, where E is set by the code in 0x2 bits 3:0. Writing 1 to 0x6 bit 0 clears it. `irq_early` is the flag gated by the interrupt enable, which writing 1 to bit 0 of 0x5 sets and writing 1 to bit 0 of 0x4 clears. Both addresses read back the enable on bit 0.
- R7: Once control bit 7 is set, writes to 0x0 and 0x1 are ignored until `rst_n` is asserted. The warning register stays writable.
- R8: Clearing run stops and zeroes the count, and no `wdt_reset` pulse follows.
- R9: The status register at 0x7 reads 0x00 and ignores writes. The kick register at 0x8 reads 0x00.
- R10: Each time-out produces a `wdt_reset` pulse one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_early | output | 1 | Early-warning interrupt |
| wdt_reset | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with BASE_LOG2=1 and MAX_CODE=5, which shrinks the intervals to 2 to 64 cycles. At that size every one of the sixteen time-out codes can be swept, clamped codes included. The full cross of four window codes with four time-out codes fits the budget, each case tried with no kick, a kick one cycle too early and a kick on the first legal cycle. The early-warning offset is also swept over every code against the longest time-out, including the case where warning and time-out land on the same edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [3:0] ADR_CTRL    = 4'h0;
  localparam logic [3:0] ADR_CFG     = 4'h1;
  localparam logic [3:0] ADR_WARN    = 4'h2;
  localparam logic [3:0] ADR_IEN_CLR = 4'h4;
  localparam logic [3:0] ADR_IEN_SET = 4'h5;
  localparam logic [3:0] ADR_FLAG    = 4'h6;
  localparam logic [3:0] ADR_STAT    = 4'h7;
  localparam logic [3:0] ADR_KICK    = 4'h8;

  localparam logic [7:0] KICK_KEY    = 8'hA5;

  localparam int BIT_RUN  = 1;
  localparam int BIT_WIN  = 2;
  localparam int BIT_LOCK = 7;

  localparam logic [3:0] CODE_RST = 4'hB;
endpackage

// File: rtl/wdt_code_to_cycles.sv
module wdt_code_to_cycles #(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11,
  parameter int CW        = 16
) (
  input  logic [3:0]    code,
  output logic [CW-1:0] cycles
);
  localparam int SHW = $clog2(BASE_LOG2 + MAX_CODE + 1) + 1;

  logic [3:0]     eff;
  logic [SHW-1:0] sh;

  always_comb begin
    eff    = (code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : code;
    sh     = SHW'(BASE_LOG2) + SHW'(eff);
    cycles = CW'(1) << sh;
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          ew_hit,
  output logic          run_q,
  output logic          win_q,
  output logic          lock_q,
  output logic [3:0]    per_code,
  output logic [3:0]    win_code,
  output logic [3:0]    warn_code,
  output logic          ien_q,
  output logic          flag_q,
  output logic          kick_ok,
  output logic          kick_bad
);
  logic hit_ctrl, hit_cfg, hit_warn, hit_iclr, hit_iset, hit_flag, hit_kick;

  always_comb begin
    hit_ctrl = reg_wr && (reg_addr == AW'(ADR_CTRL));
    hit_cfg  = reg_wr && (reg_addr == AW'(ADR_CFG));
    hit_warn = reg_wr && (reg_addr == AW'(ADR_WARN));
    hit_iclr = reg_wr && (reg_addr == AW'(ADR_IEN_CLR));
    hit_iset = reg_wr && (reg_addr == AW'(ADR_IEN_SET));
    hit_flag = reg_wr && (reg_addr == AW'(ADR_FLAG));
    hit_kick = reg_wr && (reg_addr == AW'(ADR_KICK)) && run_q;
    kick_ok  = hit_kick && (reg_wdata == KICK_KEY);
    kick_bad = hit_kick && (reg_wdata != KICK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      win_q     <= 1'b0;
      lock_q    <= 1'b0;
      per_code  <= CODE_RST;
      win_code  <= CODE_RST;
      warn_code <= CODE_RST;
      ien_q     <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (hit_ctrl && !lock_q) begin
        run_q  <= reg_wdata[BIT_RUN];
        win_q  <= reg_wdata[BIT_WIN];
        lock_q <= reg_wdata[BIT_LOCK];
      end
      if (hit_cfg && !lock_q) begin
        per_code <= reg_wdata[3:0];
        win_code <= reg_wdata[7:4];
      end
      if (hit_warn) warn_code <= reg_wdata[3:0];
      if (hit_iset && reg_wdata[0]) ien_q <= 1'b1;
      else if (hit_iclr && reg_wdata[0]) ien_q <= 1'b0;
      // a new warning event wins over a simultaneous clear
      if (ew_hit) flag_q <= 1'b1;
      else if (hit_flag && reg_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      AW'(ADR_CTRL):    reg_rdata = {lock_q, 4'b0000, win_q, run_q, 1'b0};
      AW'(ADR_CFG):     reg_rdata = {win_code, per_code};
      AW'(ADR_WARN):    reg_rdata = {4'b0000, warn_code};
      AW'(ADR_IEN_CLR): reg_rdata = {7'b0, ien_q};
      AW'(ADR_IEN_SET): reg_rdata = {7'b0, ien_q};
      AW'(ADR_FLAG):    reg_rdata = {7'b0, flag_q};
      default:          reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          win_mode,
  input  logic          kick_ok,
  input  logic          kick_bad,
  input  logic [CW-1:0] win_cyc,
  input  logic [CW-1:0] per_cyc,
  input  logic [CW-1:0] warn_cyc,
  output logic [CW-1:0] cnt,
  output logic          rst_pulse,
  output logic          ew_hit
);
  logic [CW-1:0] limit;
  logic          early;
  logic          expire;

  always_comb begin
    limit  = win_mode ? (win_cyc + per_cyc) : per_cyc;
    early  = win_mode && (cnt < win_cyc);
    expire = (cnt >= limit - CW'(1));
    ew_hit = run && !kick_ok && !kick_bad && (cnt == warn_cyc - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else if (kick_bad) begin
        rst_pulse <= 1'b1;
        cnt       <= '0;
      end else if (kick_ok) begin
        rst_pulse <= early;
        cnt       <= '0;
      end else if (expire) begin
        rst_pulse <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int AW        = 4,
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq_early,
  output logic          wdt_reset
);
  localparam int CW    = BASE_LOG2 + MAX_CODE + 2;
  localparam int NFLD  = 3;

  logic          run_q, win_q, lock_q, ien_q, flag_q;
  logic          kick_ok, kick_bad, ew_hit;
  logic [3:0]    per_code, win_code, warn_code;
  logic [3:0]    codes [NFLD];
  logic [CW-1:0] cyc   [NFLD];
  logic [CW-1:0] cnt;

  wdt_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ew_hit(ew_hit),
    .run_q(run_q), .win_q(win_q), .lock_q(lock_q),
    .per_code(per_code), .win_code(win_code), .warn_code(warn_code),
    .ien_q(ien_q), .flag_q(flag_q),
    .kick_ok(kick_ok), .kick_bad(kick_bad)
  );

  always_comb begin
    codes[0] = per_code;
    codes[1] = win_code;
    codes[2] = warn_code;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_dec
    wdt_code_to_cycles #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE), .CW(CW)) u_dec (
      .code(codes[g]), .cycles(cyc[g])
    );
  end

  wdt_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(run_q), .win_mode(win_q),
    .kick_ok(kick_ok), .kick_bad(kick_bad),
    .win_cyc(cyc[1]), .per_cyc(cyc[0]), .warn_cyc(cyc[2]),
    .cnt(cnt), .rst_pulse(wdt_reset), .ew_hit(ew_hit)
  );

  assign irq_early = flag_q & ien_q;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk
  import wdt_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          wdt_reset,
  input logic          run_q,
  input logic          win_q,
  input logic          lock_q,
  input logic          flag_q,
  input logic [3:0]    per_code,
  input logic [3:0]    win_code,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] win_cyc
);
  logic kick_wr;
  assign kick_wr = reg_wr && (reg_addr == AW'(ADR_KICK));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> (!wdt_reset || $past(reg_wr)));

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !wdt_reset);

  p_bad_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && kick_wr && reg_wdata != KICK_KEY) |=> wdt_reset);

  p_early_kick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && win_q && kick_wr && reg_wdata == KICK_KEY && cnt < win_cyc) |=> wdt_reset);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(per_code) && $stable(win_code) && $stable(run_q) && $stable(win_q)));

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(reg_wr && reg_addr == AW'(ADR_FLAG) && reg_wdata[0])) |=> flag_q);
endmodule

bind win_watchdog win_watchdog_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .wdt_reset(wdt_reset), .run_q(run_q),
  .win_q(win_q), .lock_q(lock_q), .flag_q(flag_q),
  .per_code(per_code), .win_code(win_code), .cnt(cnt), .win_cyc(cyc[1])
);

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb;
  localparam int AW = 4;
  localparam int B  = 1;
  localparam int M  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          irq_early, wdt_reset;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_watchdog #(.AW(AW), .BASE_LOG2(B), .MAX_CODE(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_early(irq_early), .wdt_reset(wdt_reset)
  );

  function automatic int cyc(input int code);
    int e;
    e = (code > M) ? M : code;
    return 1 << (B + e);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles until sel (0 = wdt_reset, 1 = irq_early) is seen high
  task automatic wait_sig(input int sel, input int maxn, output int n, output bit seen);
    n = 0;
    seen = (sel == 0) ? wdt_reset : irq_early;
    while (!seen && n < maxn) begin
      @(negedge clk);
      n++;
      seen = (sel == 0) ? wdt_reset : irq_early;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    bit seen;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(4'h0, d); check(d == 8'h00, "R1 ctrl", d, 8'h00);
    rd(4'h1, d); check(d == 8'hBB, "R1 cfg", d, 8'hBB);
    rd(4'h2, d); check(d == 8'h0B, "R1 warn", d, 8'h0B);
    rd(4'h4, d); check(d == 8'h00, "R1 ienclr", d, 0);
    rd(4'h5, d); check(d == 8'h00, "R1 ienset", d, 0);
    rd(4'h6, d); check(d == 8'h00, "R1 flag", d, 0);
    check(!wdt_reset && !irq_early, "R1 outputs", {wdt_reset, irq_early}, 0);

    // R9 status and kick read zero
    wr(4'h7, 8'hFF);
    rd(4'h7, d); check(d == 8'h00, "R9 status", d, 0);
    rd(4'h8, d); check(d == 8'h00, "R9 kick read", d, 0);

    // R2 / R10 sweep of all time-out codes, normal mode
    for (int c = 0; c < 16; c++) begin
      wr(4'h0, 8'h00);
      wr(4'h1, 8'(c));
      wr(4'h0, 8'h02);
      wait_sig(0, 200, n, seen);
      check(seen && n == cyc(c), "R2 timeout", n, cyc(c));
      @(negedge clk);
      check(!wdt_reset, "R10 pulse width", wdt_reset, 0);
    end

    // R3 key restart
    wr(4'h0, 8'h00);
    wr(4'h1, 8'h03);
    wr(4'h0, 8'h02);
    idle(10);
    wr(4'h8, 8'hA5);
    check(!wdt_reset, "R3 kick no pulse", wdt_reset, 0);
    wait_sig(0, 100, n, seen);
    check(seen && n == cyc(3), "R3 restart", n, cyc(3));

    // R4 wrong key while running
    wr(4'h0, 8'h00);
    wr(4'h0, 8'h02);
    idle(2);
    wr(4'h8, 8'h5A);
    check(wdt_reset == 1'b1, "R4 bad key", wdt_reset, 1);
    // R4 kick writes ignored while stopped
    wr(4'h0, 8'h00);
    wr(4'h8, 8'h11);
    check(!wdt_reset, "R4 stopped bad key", wdt_reset, 0);
    wait_sig(0, 70, n, seen);
    check(!seen, "R4 stopped quiet", seen, 0);

    // R8 stopping mid-count
    wr(4'h0, 8'h02);
    idle(8);
    wr(4'h0, 8'h00);
    wait_sig(0, 60, n, seen);
    check(!seen, "R8 stop no pulse", seen, 0);

    // R5 window x period cross
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        int wc, pc;
        wc = cyc(w); pc = cyc(p);
        wr(4'h0, 8'h00);
        wr(4'h1, 8'((w << 4) | p));
        wr(4'h0, 8'h06);
        wait_sig(0, 200, n, seen);
        check(seen && n == wc + pc, "R5 no kick", n, wc + pc);
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h06);
        idle(wc - 2);
        wr(4'h8, 8'hA5);
        check(wdt_reset == 1'b1, "R5 early kick", wdt_reset, 1);
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h06);
        idle(wc - 1);
        wr(4'h8, 8'hA5);
        check(!wdt_reset, "R5 open kick", wdt_reset, 0);
        wait_sig(0, 200, n, seen);
        check(seen && n == wc + pc, "R5 after kick", n, wc + pc);
      end
    end

    // R6 warning offset sweep
    for (int k = 0; k < 7; k++) begin
      int kc;
      kc = (k == 6) ? 15 : k;
      wr(4'h0, 8'h00);
      wr(4'h6, 8'h01);
      wr(4'h1, 8'h05);
      wr(4'h2, 8'(kc));
      wr(4'h5, 8'h01);
      wr(4'h0, 8'h02);
      wait_sig(1, 200, n, seen);
      check(seen && n == cyc(kc), "R6 warning", n, cyc(kc));
    end
    // R6 gating and clearing
    wr(4'h0, 8'h00);
    wr(4'h4, 8'h01);
    rd(4'h5, d); check(d == 8'h00, "R6 ien cleared", d, 0);
    check(!irq_early, "R6 irq masked", irq_early, 0);
    rd(4'h6, d); check(d == 8'h01, "R6 flag kept", d, 1);
    wr(4'h5, 8'h01);
    check(irq_early == 1'b1, "R6 irq unmasked", irq_early, 1);
    wr(4'h6, 8'h01);
    check(!irq_early, "R6 flag cleared irq", irq_early, 0);
    rd(4'h6, d); check(d == 8'h00, "R6 flag read", d, 0);

    // R7 lock
    wr(4'h1, 8'h03);
    wr(4'h0, 8'h82);
    wr(4'h0, 8'h00);
    rd(4'h0, d); check(d == 8'h82, "R7 ctrl locked", d, 8'h82);
    wr(4'h1, 8'h55);
    rd(4'h1, d); check(d == 8'h03, "R7 cfg locked", d, 8'h03);
    wr(4'h2, 8'h02);
    rd(4'h2, d); check(d == 8'h02, "R7 warn writable", d, 2);
    wr(4'h8, 8'hA5);
    wait_sig(0, 100, n, seen);
    check(seen && n == cyc(3), "R7 still running", n, cyc(3));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(4'h0, d); check(d == 8'h00, "R7 unlocked by reset", d, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule